// File: doc/BRIEF.md
# Dual Down-Counting Timer with Locked Watchdog

This block holds two independent down-counting timers and a watchdog, all reached through one word-addressed register port with separate read and write strobes. Each timer has its own mode, count and reload registers. When enabled it counts down once per tick of a selectable divided clock. It raises a terminal-count flag when its count steps onto zero. It then either reloads itself or stays at zero.

The two terminal-count flags are collected in a shared status register and driven out as interrupt lines. Each flag is cleared by writing a one. The watchdog stays off until software writes two fixed magic words to its control register, one straight after the other. Once on, it counts down on every system clock. It raises a sticky reset request when it reaches zero, unless software reloads it in time. It cannot be switched off again.

Top module: `twin_timer_wdog`

## Requirements
- R1: After reset, every register reads zero, `tc_irq` is 0 and `wd_reset_req` is 0.
- R2: A timer mode word has these fields: bit 0 is the terminal-count flag, bit 1 is enable, bit 2 is auto-reload, bit 3 is a privileged bit that is stored and read back but has no other effect, and bits 5:4 are the clock select. The enable, auto-reload, privileged and clock-select fields read back as written.
- R3: An enabled timer decrements its count once per tick. The clock select chooses one tick every 1, 4, 8 or 16 clocks for codes 0, 1, 2 and 3. The first tick lands N clocks after the enabling write, and the divider restarts whenever the timer is disabled.
- R4: On the tick that takes a count from 1 to 0, the timer's terminal-count flag is set. The flag shows in mode bit 0, in status bit i (timer 0 is bit 0, timer 1 is bit 1) and on `tc_irq[i]`.
- R5: On the tick after the count is zero, a timer with auto-reload set loads its reload value and counts on. Without auto-reload, the count stays at zero.
- R6: Writing a 1 to status bit i clears flag i. Writing a 1 to mode bit 0 clears that timer's flag. Writing 0 bits changes nothing. If a flag is set and cleared in the same cycle, the set wins.
- R7: A disabled timer holds its count. A write to the count register loads it directly and takes priority over a tick.
- R8: The watchdog turns on only when 0x1E1E1E1E and then 0xE1E1E1E1 are written to its control register in consecutive writes to that register. Any other write restarts the sequence. Control reads return bit 0 = on and bit 1 = first word seen.
- R9: Writing the watchdog reload register loads both the reload value and the watchdog count. While on, the watchdog decrements every clock. `wd_reset_req` rises V+1 clocks after the write that loaded value V (or after the enabling write) and then stays high until reset.
- R10: Once the watchdog is on, no write turns it off.
- R11: The word address map is: 0/1 mode of timer 0/1, 2/3 count, 4/5 reload, 6 status, 7 watchdog control, 8 watchdog reload, 9 watchdog count. Other addresses read 0. Read data is registered and appears the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tc_irq | output | 2 | Terminal-count flags of timers 1 and 0 |
| wd_reset_req | output | 1 | Sticky watchdog reset request |

## Verification
A register write takes effect at the clock edge that samples it. A read returns, after the edge that samples `rd_en`, the value the register held just before that edge. With divider N, timer ticks fall on the Nth, 2Nth, and later edges after the enabling write, so a read sampled k edges after that write reflects floor((k-1)/N) ticks. The interrupt lines reflect floor(k/N) ticks. The bench drives every access at the falling edge and samples there. It counts the exact number of edges between the enabling write and each read, and feeds that tick count to a stepping function. The watchdog request is sampled on the falling edges either side of the V+1th edge after the last reload.

// File: rtl/twin_timer_wdog.sv
module twin_timer_wdog #(
  parameter int W = 32,
  parameter logic [31:0] MAGIC_A = 32'h1E1E_1E1E,
  parameter logic [31:0] MAGIC_B = 32'hE1E1_E1E1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [3:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [1:0]   tc_irq,
  output logic         wd_reset_req
);
  localparam int NT = 2;
  localparam int PW = 4;
  localparam logic [3:0] A_MODE = 4'd0, A_CNT = 4'd2, A_RLD = 4'd4,
                         A_STAT = 4'd6, A_WCTL = 4'd7, A_WRLD = 4'd8, A_WCNT = 4'd9;

  logic [NT-1:0]        tc_v, en_v;
  logic [NT-1:0][5:0]   mode_v;
  logic [NT-1:0][W-1:0] cnt_v, rld_v;

  wire wr_stat = wr_en && addr == A_STAT;

  for (genvar i = 0; i < NT; i++) begin : g_t
    logic [1:0]    sel_q;
    logic          en_q, ar_q, prv_q, tc_q, tick;
    logic [PW-1:0] psc_q;
    logic [W-1:0]  cnt_q, rld_q;

    wire wr_mode = wr_en && addr == A_MODE + 4'(i);
    wire wr_cnt  = wr_en && addr == A_CNT + 4'(i);
    wire wr_rld  = wr_en && addr == A_RLD + 4'(i);
    wire step    = en_q && tick;

    always_comb
      case (sel_q)
        2'd0:    tick = 1'b1;
        2'd1:    tick = &psc_q[1:0];
        2'd2:    tick = &psc_q[2:0];
        default: tick = &psc_q;
      endcase

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        {sel_q, prv_q, ar_q, en_q, tc_q} <= '0;
        psc_q <= '0;
        cnt_q <= '0;
        rld_q <= '0;
      end else begin
        psc_q <= en_q ? psc_q + 1'b1 : '0;
        if (wr_mode) {sel_q, prv_q, ar_q, en_q} <= wdata[5:1];
        if (wr_rld) rld_q <= wdata;
        if (wr_cnt) cnt_q <= wdata;
        else if (step) cnt_q <= (cnt_q != '0) ? cnt_q - 1'b1 : (ar_q ? rld_q : cnt_q);
        if (step && !wr_cnt && cnt_q == W'(1)) tc_q <= 1'b1;
        else if ((wr_stat && wdata[i]) || (wr_mode && wdata[0])) tc_q <= 1'b0;
      end
    end

    assign tc_v[i]   = tc_q;
    assign en_v[i]   = en_q;
    assign cnt_v[i]  = cnt_q;
    assign rld_v[i]  = rld_q;
    assign mode_v[i] = {sel_q, prv_q, ar_q, en_q, tc_q};
  end

  assign tc_irq = tc_v;

  logic         wd_en, wd_stage;
  logic [W-1:0] wd_rld, wd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_en <= 1'b0;
      wd_stage <= 1'b0;
      wd_rld <= '0;
      wd_cnt <= '0;
      wd_reset_req <= 1'b0;
    end else begin
      if (wr_en && addr == A_WCTL && !wd_en) begin
        if (wd_stage && wdata == W'(MAGIC_B)) begin
          wd_en <= 1'b1;
          wd_stage <= 1'b0;
        end else wd_stage <= (wdata == W'(MAGIC_A));
      end
      if (wr_en && addr == A_WRLD) begin
        wd_rld <= wdata;
        wd_cnt <= wdata;
      end else if (wd_en && wd_cnt != '0) wd_cnt <= wd_cnt - 1'b1;
      if (wd_en && wd_cnt == '0) wd_reset_req <= 1'b1;
    end
  end

  logic [W-1:0] rd_mux;
  always_comb
    case (addr)
      4'd0, 4'd1: rd_mux = {{(W-6){1'b0}}, mode_v[addr[0]]};
      4'd2, 4'd3: rd_mux = cnt_v[addr[0]];
      4'd4, 4'd5: rd_mux = rld_v[addr[0]];
      A_STAT:     rd_mux = {{(W-NT){1'b0}}, tc_v};
      A_WCTL:     rd_mux = {{(W-2){1'b0}}, wd_stage, wd_en};
      A_WRLD:     rd_mux = wd_rld;
      A_WCNT:     rd_mux = wd_cnt;
      default:    rd_mux = '0;
    endcase

  always_ff @(posedge clk)
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
endmodule

module twin_timer_wdog_chk #(parameter int W = 32) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [3:0]   addr,
  input logic         wd_en,
  input logic         wd_reset_req,
  input logic [1:0]   tc_v,
  input logic [1:0]   en_v,
  input logic [1:0][W-1:0] cnt_v
);
  assert_tc_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_v[0]) |-> cnt_v[0] == '0);
  assert_tc1_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_v[1]) |-> cnt_v[1] == '0);
  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_v[0] && !(wr_en && addr == 4'd2)) |=> $stable(cnt_v[0]));
  assert_wd_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset_req |=> wd_reset_req);
  assert_wd_no_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en |=> wd_en);
  assert_rst_only_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_reset_req) |-> wd_en);
endmodule

bind twin_timer_wdog twin_timer_wdog_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wd_en(wd_en),
  .wd_reset_req(wd_reset_req), .tc_v(tc_v), .en_v(en_v), .cnt_v(cnt_v));

// File: tb/twin_timer_wdog_bench.sv
`timescale 1ns/1ps
module twin_timer_wdog_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] tc_irq;
  logic wd_reset_req;
  int total = 0, bad = 0;

  twin_timer_wdog u_twin_timer_wdog (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tc_irq(tc_irq), .wd_reset_req(wd_reset_req));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic model(input logic [31:0] s, input logic [31:0] r, input bit ar, input int t,
                       output logic [31:0] c, output bit f);
    c = s; f = 1'b0;
    for (int k = 0; k < t; k++)
      if (c != 0) begin
        c = c - 1;
        if (c == 0) f = 1'b1;
      end else if (ar) c = r;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL run timeout (all requirements) actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, ec;
    bit ef;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      chk($sformatf("R1 reset reg %0d", a), d, 32'h0);
    end
    chk("R1 irq at reset", {30'b0, tc_irq}, 32'h0);
    chk("R1 wd req at reset", {31'b0, wd_reset_req}, 32'h0);

    wr(4'd0, 32'h38);
    rd(4'd0, d);
    chk("R2 mode fields readback", d, 32'h38);
    wr(4'd2, 32'd5);
    repeat (20) @(negedge clk);
    rd(4'd2, d);
    chk("R7 disabled timer holds", d, 32'd5);
    rd(4'd15, d);
    chk("R11 unmapped reads zero", d, 32'h0);

    for (int it = 0; it < 24; it++) begin
      int ti, c, nd;
      logic [31:0] s, r;
      bit ar;
      logic [1:0] sel;
      ti = it % 2;
      s = 1 + $urandom % 30;
      r = $urandom % 20;
      ar = 1'($urandom % 2);
      sel = 2'($urandom % 4);
      if (it < 4) sel = 2'(it);
      nd = (sel == 0) ? 1 : (4 << (sel - 1));
      c = 1 + $urandom % 120;
      wr(4'(ti), 32'h0);
      wr(4'd6, 32'h3);
      wr(4'(2 + ti), s);
      wr(4'(4 + ti), r);
      wr(4'(ti), {26'b0, sel, 1'b0, ar, 1'b1, 1'b0});
      repeat (c - 1) @(negedge clk);
      rd(4'(2 + ti), d);
      model(s, r, ar, (c - 1) / nd, ec, ef);
      chk($sformatf("R3 R5 count t%0d sel%0d ar%0d", ti, sel, ar), d, ec);
      rd(4'd6, d);
      model(s, r, ar, c / nd, ec, ef);
      chk($sformatf("R4 status bit t%0d", ti), {31'b0, d[ti]}, {31'b0, ef});
      rd(4'(ti), d);
      model(s, r, ar, (c + 1) / nd, ec, ef);
      chk($sformatf("R4 mode mirror t%0d", ti), {31'b0, d[0]}, {31'b0, ef});
      chk($sformatf("R2 mode fields t%0d", ti), {26'b0, d[5:1], 1'b0}, {26'b0, sel, 1'b0, ar, 1'b1, 1'b0});
      model(s, r, ar, (c + 2) / nd, ec, ef);
      chk($sformatf("R4 irq line t%0d", ti), {31'b0, tc_irq[ti]}, {31'b0, ef});
    end

    wr(4'd0, 32'h0); wr(4'd1, 32'h0); wr(4'd6, 32'h3);
    wr(4'd2, 32'd2);
    wr(4'd0, 32'h2);
    repeat (10) @(negedge clk);
    rd(4'd2, d);
    chk("R5 no reload stops at zero", d, 32'h0);
    wr(4'd3, 32'd1);
    wr(4'd1, 32'h2);
    repeat (2) @(negedge clk);
    rd(4'd6, d);
    chk("R4 both flags set", d, 32'h3);
    wr(4'd6, 32'h0);
    rd(4'd6, d);
    chk("R6 zero write no effect", d, 32'h3);
    wr(4'd6, 32'h1);
    rd(4'd6, d);
    chk("R6 clear bit0 only", d, 32'h2);
    wr(4'd1, 32'h1);
    rd(4'd6, d);
    chk("R6 clear via mode bit0", d, 32'h0);
    chk("R6 irq low after clear", {30'b0, tc_irq}, 32'h0);

    wr(4'd8, 32'd25);
    wr(4'd7, 32'h1E1E1E1E);
    wr(4'd7, 32'h5);
    wr(4'd7, 32'hE1E1E1E1);
    rd(4'd7, d);
    chk("R8 broken sequence stays off", d, 32'h0);
    repeat (40) @(negedge clk);
    chk("R8 no request while off", {31'b0, wd_reset_req}, 32'h0);
    rd(4'd9, d);
    chk("R9 count frozen while off", d, 32'd25);
    wr(4'd7, 32'hE1E1E1E1);
    rd(4'd7, d);
    chk("R8 second word alone", d, 32'h0);
    wr(4'd7, 32'h1E1E1E1E);
    rd(4'd7, d);
    chk("R8 first word seen", d, 32'h2);
    wr(4'd7, 32'hE1E1E1E1);
    rd(4'd7, d);
    chk("R8 watchdog on", d, 32'h1);
    wr(4'd8, 32'd25);
    wr(4'd7, 32'h0);
    rd(4'd7, d);
    chk("R10 cannot disable", d, 32'h1);
    repeat (23) @(negedge clk);
    chk("R9 no request before expiry", {31'b0, wd_reset_req}, 32'h0);
    @(negedge clk);
    chk("R9 request at expiry", {31'b0, wd_reset_req}, 32'h1);
    repeat (10) @(negedge clk);
    chk("R9 request sticky", {31'b0, wd_reset_req}, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule